// File: doc/BRIEF.md
# Global Control, Status and Codec Semaphore Registers

This block holds the registers that three audio DMA channels (record, playback and microphone) share. The channels live elsewhere. The block sits behind a 64-byte register window that is reached through a simple byte or dword access port.

It holds four pieces of state:
- A six-bit global control register. Writing a reset-request bit does not update it; the write becomes a one-cycle warm or cold reset pulse instead.
- An 18-bit global status word. It mixes read/write bits, read-only bits and write-1-to-clear event bits. It also mirrors the three channel interrupt requests into fixed bit positions.
- A single combined interrupt line, driven by the mirrored channel interrupts.
- A one-bit codec-access semaphore. A byte read returns its value and then takes it. Any access to the mixer window releases it.

Read data is combinational from the current state while a read is presented. Side effects happen at the clock edge that completes the access. Control writes, status writes, semaphore reads and interrupt mirroring all take effect one cycle after the edge that samples them.

Top module: `gcs_regs`

## Requirements
- R1: A dword write to offset 0x2C with data bits 2 and 1 both clear stores data bits 5:0 in the control register. A dword read of 0x2C returns them zero-extended. Control resets to 0.
- R2: A dword write to 0x2C with bit 2 or bit 1 set leaves the control register unchanged.
- R3: Such a write drives `warm_rst_pulse` high for exactly the cycle after the write if bit 2 was set, and `cold_rst_pulse` likewise if bit 1 was set. Both pulse together when both bits are set. Otherwise both stay low.
- R4: Status bits 5, 6 and 7 (dword read at 0x30) show the record, playback and mic interrupt inputs (`chan_irq[0]`, `[1]`, `[2]`) as sampled at the previous clock edge.
- R5: `irq_out` is high exactly when at least one of the three mirrored channel interrupt bits is high, that is, one cycle after the input.
- R6: Status bits 15, 11, 10 and 0 reset to 1 (parameter default). A dword status write with 1 in one of those positions clears that bit. A 0 leaves it. Nothing else sets them.
- R7: Status bit 8 always reads 1. Status bits 14:12, 9 and 4:1 always read 0, and status writes do not change them.
- R8: Status bits 17:16 are read/write. They reset to 0 and take data bits 17:16 on a dword status write. Status bits above 17 read 0.
- R9: A byte read at 0x34 returns the semaphore in bit 0, with bits 31:1 at 0, and then sets the semaphore to 1. The semaphore resets to 0.
- R10: `mixer_access` clears the semaphore at the next edge. It takes priority over a semaphore read in the same cycle, which still returns the old value.
- R11: A read of any other offset or size returns all ones. This includes byte reads of 0x2C and 0x30, dword reads of 0x34 and the channel register area 0x00–0x2B. Writes to any location other than dword 0x2C or 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write access this cycle |
| acc_rd | input | 1 | Read access this cycle |
| acc_dword | input | 1 | 1 = dword access, 0 = byte access |
| acc_addr | input | 6 | Byte offset inside the 64-byte window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the presented access |
| chan_irq | input | 3 | Channel interrupt requests: 0 record, 1 playback, 2 mic |
| mixer_access | input | 1 | Strobe: the mixer window was accessed |
| irq_out | output | 1 | Combined interrupt |
| warm_rst_pulse | output | 1 | One-cycle warm reset request |
| cold_rst_pulse | output | 1 | One-cycle cold reset request |

## Verification
The embedded properties check the following on every cycle:
- A reset-request write leaves control untouched.
- Each reset pulse traces back to a write that carried its bit.
- The interrupt output follows an interrupt input from the cycle before.
- Event bits only fall, and fall after a one is written to them.
- The semaphore is taken by a read and released by a mixer access.

The bench scenarios are needed for the rest:
- The exact bit layout of the status word.
- That an unmapped or wrong-size read returns all ones.
- That the semaphore read returns the value from before its own side effect.
- That mixing reads, writes, interrupt changes and mixer strobes in random order keeps every register consistent with an independent model.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int N_CHAN  = 3;
    localparam int CTRL_W  = 6;
    localparam int STA_W   = 18;
    localparam int N_EVT   = 4;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 6'h2C;
    localparam logic [ADDR_W-1:0] OFF_STAT = 6'h30;
    localparam logic [ADDR_W-1:0] OFF_SEM  = 6'h34;

    localparam int WARM_BIT  = 2;
    localparam int COLD_BIT  = 1;
    localparam int IRQ_BASE  = 5;
    localparam int READY_BIT = 8;
    localparam int RW_LO     = 16;
    localparam int RW_W      = 2;

    // Status positions of the write-1-to-clear event bits
    localparam int EVT_POS [N_EVT] = '{0, 10, 11, 15};

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_STAT,
        TGT_SEM
    } reg_tgt_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              dword;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    function automatic reg_tgt_e decode_target(input logic [ADDR_W-1:0] addr,
                                               input logic dword);
        reg_tgt_e t;
        t = TGT_NONE;
        if (dword && addr == OFF_CTRL)       t = TGT_CTRL;
        else if (dword && addr == OFF_STAT)  t = TGT_STAT;
        else if (!dword && addr == OFF_SEM)  t = TGT_SEM;
        return t;
    endfunction

    function automatic logic has_reset_req(input logic [CTRL_W-1:0] v);
        return v[WARM_BIT] | v[COLD_BIT];
    endfunction

endpackage

// File: rtl/gcs_ctrl_reg.sv
module gcs_ctrl_reg
    import gcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wr_val,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              warm_pulse,
    output logic              cold_pulse
);

    logic req_reset;
    assign req_reset = has_reset_req(wr_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            warm_pulse <= 1'b0;
            cold_pulse <= 1'b0;
        end else begin
            warm_pulse <= wr_ctrl & wr_val[WARM_BIT];
            cold_pulse <= wr_ctrl & wr_val[COLD_BIT];
            if (wr_ctrl && !req_reset)
                ctrl_q <= wr_val;
        end
    end

    // R2: a reset-request write keeps the stored control value
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && req_reset) |=> $stable(ctrl_q));

    // R3: each pulse comes from a write carrying its bit
    p_warm_src_r3: assert property (@(posedge clk) disable iff (rst)
        warm_pulse |-> $past(wr_ctrl && wr_val[WARM_BIT]));
    p_cold_src_r3: assert property (@(posedge clk) disable iff (rst)
        cold_pulse |-> $past(wr_ctrl && wr_val[COLD_BIT]));

endmodule

// File: rtl/gcs_status_reg.sv
module gcs_status_reg
    import gcs_pkg::*;
#(
    parameter logic [N_EVT-1:0] EVT_INIT = '1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic [STA_W-1:0]  wr_val,
    input  logic [N_CHAN-1:0] chan_irq,
    output logic [STA_W-1:0]  sta_word,
    output logic              irq_any
);

    logic [N_CHAN-1:0] irq_q;
    logic [RW_W-1:0]   rw_q;
    logic [N_EVT-1:0]  evt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            rw_q  <= '0;
        end else begin
            irq_q <= chan_irq;
            if (wr_stat)
                rw_q <= wr_val[RW_LO +: RW_W];
        end
    end

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        always_ff @(posedge clk) begin
            if (rst)
                evt_q[e] <= EVT_INIT[e];
            else if (wr_stat && wr_val[EVT_POS[e]])
                evt_q[e] <= 1'b0;
        end

        // R6: writing a one clears the event bit
        p_evt_clear_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_stat && wr_val[EVT_POS[e]]) |=> !evt_q[e]);
        // R6: nothing sets a cleared event bit
        p_evt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            !evt_q[e] |=> !evt_q[e]);
    end

    always_comb begin
        sta_word = '0;
        sta_word[READY_BIT] = 1'b1;
        sta_word[RW_LO +: RW_W] = rw_q;
        for (int e = 0; e < N_EVT; e++)
            sta_word[EVT_POS[e]] = evt_q[e];
        for (int c = 0; c < N_CHAN; c++)
            sta_word[IRQ_BASE + c] = irq_q[c];
    end

    assign irq_any = |irq_q;

    // R5: combined interrupt only follows a request from the cycle before
    p_irq_src_r5: assert property (@(posedge clk) disable iff (rst)
        irq_any |-> $past(|chan_irq));

endmodule

// File: rtl/gcs_semaphore.sv
module gcs_semaphore (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic release_req,
    output logic sem_q
);

    always_ff @(posedge clk) begin
        if (rst)
            sem_q <= 1'b0;
        else if (release_req)
            sem_q <= 1'b0;
        else if (take)
            sem_q <= 1'b1;
    end

    // R9: a read without a release takes the semaphore
    p_sem_take_r9: assert property (@(posedge clk) disable iff (rst)
        (take && !release_req) |=> sem_q);

    // R10: a mixer access always releases it
    p_sem_release_r10: assert property (@(posedge clk) disable iff (rst)
        release_req |=> !sem_q);

endmodule

// File: rtl/gcs_regs.sv
module gcs_regs
    import gcs_pkg::*;
#(
    parameter logic [N_EVT-1:0] EVT_INIT = '1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic              acc_dword,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic [N_CHAN-1:0] chan_irq,
    input  logic              mixer_access,
    output logic              irq_out,
    output logic              warm_rst_pulse,
    output logic              cold_rst_pulse
);

    acc_req_t          req;
    reg_tgt_e          tgt;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STA_W-1:0]  sta_word;
    logic              sem_q;

    assign req = '{wr: acc_wr, rd: acc_rd, dword: acc_dword,
                   addr: acc_addr, wdata: acc_wdata};
    assign tgt = decode_target(req.addr, req.dword);

    gcs_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (req.wr && tgt == TGT_CTRL),
        .wr_val     (req.wdata[CTRL_W-1:0]),
        .ctrl_q     (ctrl_q),
        .warm_pulse (warm_rst_pulse),
        .cold_pulse (cold_rst_pulse)
    );

    gcs_status_reg #(.EVT_INIT(EVT_INIT)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_stat  (req.wr && tgt == TGT_STAT),
        .wr_val   (req.wdata[STA_W-1:0]),
        .chan_irq (chan_irq),
        .sta_word (sta_word),
        .irq_any  (irq_out)
    );

    gcs_semaphore u_sem (
        .clk         (clk),
        .rst         (rst),
        .take        (req.rd && tgt == TGT_SEM),
        .release_req (mixer_access),
        .sem_q       (sem_q)
    );

    always_comb begin
        acc_rdata = '1;
        unique case (tgt)
            TGT_CTRL: acc_rdata = DATA_W'(ctrl_q);
            TGT_STAT: acc_rdata = DATA_W'(sta_word);
            TGT_SEM:  acc_rdata = DATA_W'(sem_q);
            default:  acc_rdata = '1;
        endcase
    end

    // R7: the ready bit is present on every status read
    always_comb begin
        if (!rst && acc_rd && tgt == TGT_STAT)
            a_ready_bit_r7: assert (acc_rdata[READY_BIT]);
    end

endmodule

// File: tb/gcs_regs_test.sv
module gcs_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_wr = 1'b0, acc_rd = 1'b0, acc_dword = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [2:0]  chan_irq = '0;
    logic        mixer_access = 1'b0;
    logic        irq_out, warm_rst_pulse, cold_rst_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model
    logic [5:0] m_ctrl;
    logic [1:0] m_rw;
    logic [3:0] m_evt;   // positions 0,10,11,15
    logic [2:0] m_irq;
    logic       m_sem, m_warm, m_cold;

    always #4 clk = ~clk;

    gcs_regs uut (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_dword(acc_dword), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .chan_irq(chan_irq), .mixer_access(mixer_access),
        .irq_out(irq_out), .warm_rst_pulse(warm_rst_pulse),
        .cold_rst_pulse(cold_rst_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[17:16] = m_rw;
        s[15] = m_evt[3]; s[11] = m_evt[2]; s[10] = m_evt[1]; s[0] = m_evt[0];
        s[8] = 1'b1;
        s[7:5] = m_irq;
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic dw, input logic [5:0] a);
        if (dw && a == 6'h2C) return {26'b0, m_ctrl};
        if (dw && a == 6'h30) return exp_status();
        if (!dw && a == 6'h34) return {31'b0, m_sem};
        return 32'hFFFF_FFFF;
    endfunction

    function automatic string req_of(input logic dw, input logic [5:0] a);
        if (dw && a == 6'h2C) return "R1";
        if (dw && a == 6'h30) return "R4/R6/R7/R8";
        if (!dw && a == 6'h34) return "R9/R10";
        return "R11";
    endfunction

    // One access cycle: drive at negedge, sample read before edge,
    // update model at edge, check registered outputs at next negedge.
    task automatic step(input logic wr, input logic rd, input logic dw,
                        input logic [5:0] a, input logic [31:0] d,
                        input logic mix, input logic [2:0] irq);
        acc_wr = wr; acc_rd = rd; acc_dword = dw; acc_addr = a;
        acc_wdata = d; mixer_access = mix; chan_irq = irq;
        #2;
        if (rd) check(req_of(dw, a), acc_rdata, exp_read(dw, a));
        @(posedge clk);
        m_irq = irq;
        m_warm = 1'b0; m_cold = 1'b0;
        if (wr && dw && a == 6'h2C) begin
            if (d[2] || d[1]) begin
                m_warm = d[2]; m_cold = d[1];
            end else m_ctrl = d[5:0];
        end
        if (wr && dw && a == 6'h30) begin
            m_rw = d[17:16];
            m_evt = m_evt & ~{d[15], d[11], d[10], d[0]};
        end
        if (mix) m_sem = 1'b0;
        else if (rd && !dw && a == 6'h34) m_sem = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0; mixer_access = 1'b0;
        check("R3 warm", {31'b0, warm_rst_pulse}, {31'b0, m_warm});
        check("R3 cold", {31'b0, cold_rst_pulse}, {31'b0, m_cold});
        check("R5 irq_out", {31'b0, irq_out}, {31'b0, |m_irq});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        m_ctrl = '0; m_rw = '0; m_evt = 4'hF; m_irq = '0;
        m_sem = 1'b0; m_warm = 1'b0; m_cold = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        step(0, 1, 1, 6'h2C, 0, 0, 3'b000);          // R1 ctrl resets to 0
        step(0, 1, 1, 6'h30, 0, 0, 3'b000);          // R6 R7 R8 reset status
        check("R6 reset status", exp_status(), 32'h0000_8D01);
        // semaphore: first read 0, then 1
        step(0, 1, 0, 6'h34, 0, 0, 3'b000);          // R9
        step(0, 1, 0, 6'h34, 0, 0, 3'b000);          // R9 now 1
        // read and mixer in same cycle: old value, then released
        step(0, 1, 0, 6'h34, 0, 1, 3'b000);          // R10
        step(0, 1, 0, 6'h34, 0, 0, 3'b000);          // R10 reads 0
        step(0, 0, 0, 6'h00, 0, 1, 3'b000);          // R10 mixer alone
        step(0, 1, 0, 6'h34, 0, 0, 3'b000);
        // control store and reset requests
        step(1, 0, 1, 6'h2C, 32'hFFFF_FFF9, 0, 3'b000); // R1 stores 0x39
        step(0, 1, 1, 6'h2C, 0, 0, 3'b000);
        step(1, 0, 1, 6'h2C, 32'h0000_0004, 0, 3'b000); // R2 R3 warm
        step(1, 0, 1, 6'h2C, 32'h0000_0002, 0, 3'b000); // R2 R3 cold
        step(1, 0, 1, 6'h2C, 32'h0000_0006, 0, 3'b000); // R3 both
        step(0, 1, 1, 6'h2C, 0, 0, 3'b000);             // R2 unchanged
        // interrupts
        step(0, 1, 1, 6'h30, 0, 0, 3'b001);             // R4 record
        step(0, 1, 1, 6'h30, 0, 0, 3'b010);             // R4 playback
        step(0, 1, 1, 6'h30, 0, 0, 3'b100);             // R4 mic
        step(0, 1, 1, 6'h30, 0, 0, 3'b000);             // R5 falls
        // status write: R6 clear one, R7 RO untouched, R8 rw
        step(1, 0, 1, 6'h30, 32'h0002_0400, 0, 3'b000);
        step(0, 1, 1, 6'h30, 0, 0, 3'b000);
        step(1, 0, 1, 6'h30, 32'hFFFF_FFFF, 0, 3'b111);
        step(0, 1, 1, 6'h30, 0, 0, 3'b111);
        check("R6 all cleared", {28'b0, m_evt}, 32'h0);
        // R11 unmapped and wrong size
        step(0, 1, 0, 6'h2C, 0, 0, 3'b000);
        step(0, 1, 0, 6'h30, 0, 0, 3'b000);
        step(0, 1, 1, 6'h34, 0, 0, 3'b000);
        step(0, 1, 1, 6'h10, 0, 0, 3'b000);
        step(0, 1, 1, 6'h3C, 0, 0, 3'b000);
        step(1, 0, 1, 6'h20, 32'hFFFF_FFFF, 0, 3'b000); // R11 ignored write
        step(1, 0, 0, 6'h2C, 32'hFFFF_FFFF, 0, 3'b000); // R11 byte write
        step(0, 1, 1, 6'h2C, 0, 0, 3'b000);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [5:0]  a;
            logic        dw, wr, rd, mix;
            logic [31:0] d;
            case ($urandom_range(0, 3))
                0: a = 6'h2C;
                1: a = 6'h30;
                2: a = 6'h34;
                default: a = 6'($urandom_range(0, 63));
            endcase
            dw  = ($urandom_range(0, 3) != 0);
            wr  = ($urandom_range(0, 2) == 0);
            rd  = !wr;
            mix = ($urandom_range(0, 5) == 0);
            d   = $urandom();
            if ($urandom_range(0, 1) == 0) d[2:1] = 2'b00;
            step(wr, rd, dw, a, d, mix, 3'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule